// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the purely combinational arithmetic and logic stage of a 32-bit integer pipeline. Each operation takes a first operand and a second operand. The second operand is either a second register value or a 16-bit constant that the block widens itself. The block produces a result word and the next values of four condition flags: zero, negative, overflow and carry. The surrounding pipeline supplies the current flags, an operation code, a special-function field, a flag-write enable and an already evaluated condition bit. The pipeline registers whatever comes out.

How the constant is widened depends on the operation. The shift operations need no separate direction control. One signed shift amount, taken from the second register or from the sign-extended constant, gives both the direction and the distance. Special-function encodings that are not defined raise an illegal-operation output and have no other effect.

Top module: `alu_exec`

## Requirements
- R1: In constant form (`use_imm`=1) for op codes 000 to 011, 101 and 110, the constant goes into bits 31:16 when `imm_high`=1 and into bits 15:0 when `imm_high`=0. The other half of the operand is zero.
- R2: In constant form with op 100 (and), the half of the operand that the constant does not fill is all ones.
- R3: Op 000 computes a+b. Op 001 computes a+b+C. Op 010 computes a+~b+1. Op 011 computes a+~b+C. C is `flags_in[0]`.
- R4: Op 100 gives a AND b, op 101 gives a OR b, and op 110 gives a XOR b.
- R5: Op 111 is a shift by a signed amount. The amount is the sign-extended constant in constant form, or `src_b` in register form. Amounts 1 to 31 shift left and -1 to -31 shift right. An amount of 0 returns `src_a` unchanged. In constant form, `imm_high` selects an arithmetic (1) or logical (0) right shift.
- R6: In register form with op 111, `spec_fn` decodes as follows. 10xxx is a logical shift. 11xxx is an arithmetic shift. 00000 selects `src_a` when `cond_true`=1 and `src_b` when `cond_true`=0.
- R7: A shift amount of 32 or more gives zero. An amount of -32 or less gives zero, except for an arithmetic shift of a negative operand, which gives all ones. Both cases clear C.
- R8: When `flag_en`=0, `flags_out` equals `flags_in`. The flag bits are Z=bit 3, N=bit 2, V=bit 1 and C=bit 0.
- R9: When flags are written, Z is 1 exactly when the result is zero, and N is result bit 31.
- R10: When flags are written, V for ops 000 to 011 is 1 when both addends (b inverted for subtraction) have the same sign and the result's sign differs from it. V is 0 for every other operation.
- R11: When flags are written, C for ops 000 to 011 is the carry out of bit 31. For a left shift, C is the last bit shifted out. For all other operations, C is 0.
- R12: In register form with op 111, any `spec_fn` other than 00000, 10xxx or 11xxx sets `illegal`=1, forces the result to 0 and leaves the flags unchanged. In constant form, `spec_fn` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Constant for constant form |
| use_imm | input | 1 | 1 selects constant form |
| imm_high | input | 1 | Places the constant in the upper half; in constant-form shifts, selects arithmetic |
| op_code | input | 3 | Operation code |
| spec_fn | input | 5 | Special-function field (register form, op 111) |
| flag_en | input | 1 | Allows the flags to be written |
| flags_in | input | 4 | Current flags {Z,N,V,C} |
| cond_true | input | 1 | Evaluated condition for select |
| result | output | 32 | Result word |
| flags_out | output | 4 | Next flags {Z,N,V,C} |
| illegal | output | 1 | Reserved special encoding |

## Verification
The block holds no state, so an internal error appears at the ports in the same cycle as the operand that triggers it. A wrong widening fill, carry-in choice or shift stage corrupts `result` for that input pattern. The fault stays hidden until an input exercises it. For this reason the stimulus covers each fill case, each carry-in source and shift distances that use every barrel stage, in both directions. Flag errors often leave `result` intact, so the expected flags are compared on every operation, including those where the flags should hold or should clear.

// File: rtl/alu_exec_pkg.sv
`timescale 1ns/1ps
package alu_exec_pkg;
   typedef enum logic [2:0] {
      OP_ADD   = 3'b000,
      OP_ADDC  = 3'b001,
      OP_SUB   = 3'b010,
      OP_SUBB  = 3'b011,
      OP_AND   = 3'b100,
      OP_OR    = 3'b101,
      OP_XOR   = 3'b110,
      OP_SPCL  = 3'b111
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic v;
      logic c;
   } alu_flags_t;

   localparam int FLAG_W = 4;
endpackage

// File: rtl/alu_operand_sel.sv
`timescale 1ns/1ps
module alu_operand_sel
   import alu_exec_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 16
)(
   input  logic [W-1:0]     src_b,
   input  logic [IMM_W-1:0] imm,
   input  logic             use_imm,
   input  logic             imm_high,
   input  logic [2:0]       op_code,
   output logic [W-1:0]     opnd_b
);
   localparam int FILL_W = W - IMM_W;

   generate
      if (IMM_W < 2 || FILL_W < 1) begin : g_bad_width
         $error("alu_operand_sel: constant must be narrower than the word");
      end
   endgenerate

   logic          fill_bit;
   logic [W-1:0]  placed;

   always_comb begin
      fill_bit = (alu_op_e'(op_code) == OP_AND);
      if (imm_high)
         placed = {imm, {FILL_W{fill_bit}}};
      else
         placed = {{FILL_W{fill_bit}}, imm};
      if (!use_imm)
         opnd_b = src_b;
      else if (alu_op_e'(op_code) == OP_SPCL)
         opnd_b = {{FILL_W{imm[IMM_W-1]}}, imm};
      else
         opnd_b = placed;
   end

   always_comb begin
      if (use_imm && alu_op_e'(op_code) == OP_AND)
         assert_and_fill_R2: assert (imm_high ? (opnd_b[FILL_W-1:0] == '1)
                                             : (opnd_b[W-1:IMM_W] == '1));
   end
endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
   parameter int W = 32
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   mode,
   input  logic         c_in,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         ovf
);
   logic [W-1:0] addend;
   logic         cin;
   logic [W:0]   wide;

   always_comb begin
      addend = mode[1] ? ~b : b;
      cin    = mode[0] ? c_in : mode[1];
      wide   = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin};
      sum    = wide[W-1:0];
      carry  = wide[W];
      ovf    = (a[W-1] == addend[W-1]) && (sum[W-1] != a[W-1]);
   end

   always_comb begin
      if (a[W-1] != addend[W-1])
         assert_no_mixed_sign_ovf_R10: assert (!ovf);
   end
endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter #(
   parameter int W = 32
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] amt,
   input  logic         arith,
   output logic [W-1:0] out,
   output logic         carry
);
   localparam int SW = $clog2(W);
   localparam logic signed [W-1:0] MAX_AMT = W - 1;

   generate
      if ((1 << SW) != W || W < 4) begin : g_bad_width
         $error("alu_shifter: width must be a power of two of at least 4");
      end
   endgenerate

   logic          go_left, go_right, zero_amt, sign_fill;
   logic [SW-1:0] l_dist, r_dist;
   logic [SW:0][W:0]   lstg;
   logic [SW:0][W-1:0] rstg;

   always_comb begin
      zero_amt  = (amt == '0);
      go_left   = ($signed(amt) > 0) && ($signed(amt) <= MAX_AMT);
      go_right  = ($signed(amt) < 0) && ($signed(amt) >= -MAX_AMT);
      l_dist    = amt[SW-1:0];
      r_dist    = ~amt[SW-1:0] + 1'b1;
      sign_fill = arith & a[W-1];
   end

   assign lstg[0] = {1'b0, a};
   assign rstg[0] = a;

   generate
      for (genvar i = 0; i < SW; i++) begin : g_stage
         localparam int STEP = 1 << i;
         assign lstg[i+1] = l_dist[i] ? {lstg[i][W-STEP:0], {STEP{1'b0}}} : lstg[i];
         assign rstg[i+1] = r_dist[i] ? {{STEP{sign_fill}}, rstg[i][W-1:STEP]} : rstg[i];
      end
   endgenerate

   always_comb begin
      carry = 1'b0;
      if (zero_amt)
         out = a;
      else if (go_left) begin
         out   = lstg[SW][W-1:0];
         carry = lstg[SW][W];
      end else if (go_right)
         out = rstg[SW];
      else if ($signed(amt) < 0)
         out = {W{sign_fill}};
      else
         out = '0;
   end

   always_comb begin
      if ($signed(amt) < 0)
         assert_right_clears_c_R11: assert (!carry);
      if (zero_amt)
         assert_zero_amt_passes_R5: assert (out == a);
   end
endmodule

// File: rtl/alu_exec.sv
`timescale 1ns/1ps
module alu_exec
   import alu_exec_pkg::*;
#(
   parameter int W      = 32,
   parameter int IMM_W  = 16,
   parameter int SPEC_W = 5
)(
   input  logic [W-1:0]      src_a,
   input  logic [W-1:0]      src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  logic              imm_high,
   input  logic [2:0]        op_code,
   input  logic [SPEC_W-1:0] spec_fn,
   input  logic              flag_en,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic              cond_true,
   output logic [W-1:0]      result,
   output logic [FLAG_W-1:0] flags_out,
   output logic              illegal
);
   generate
      if (SPEC_W < 2) begin : g_bad_spec
         $error("alu_exec: special field needs at least two bits");
      end
   endgenerate

   alu_flags_t    cur, nxt;
   logic [W-1:0]  opnd_b, sum, sh_out;
   logic          add_c, add_v, sh_c;
   logic          is_arith, is_spcl, is_shift, is_sel, sh_arith;
   alu_op_e       op;

   assign op  = alu_op_e'(op_code);
   assign cur = alu_flags_t'(flags_in);

   alu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_opsel (
      .src_b   (src_b),
      .imm     (imm),
      .use_imm (use_imm),
      .imm_high(imm_high),
      .op_code (op_code),
      .opnd_b  (opnd_b)
   );

   alu_addsub #(.W(W)) u_addsub (
      .a    (src_a),
      .b    (opnd_b),
      .mode (op_code[1:0]),
      .c_in (cur.c),
      .sum  (sum),
      .carry(add_c),
      .ovf  (add_v)
   );

   alu_shifter #(.W(W)) u_shift (
      .a    (src_a),
      .amt  (opnd_b),
      .arith(sh_arith),
      .out  (sh_out),
      .carry(sh_c)
   );

   always_comb begin
      is_arith = ~op_code[2];
      is_spcl  = (op == OP_SPCL);
      is_shift = is_spcl && (use_imm || spec_fn[SPEC_W-1]);
      is_sel   = is_spcl && !use_imm && (spec_fn == '0);
      illegal  = is_spcl && !is_shift && !is_sel;
      sh_arith = use_imm ? imm_high : spec_fn[SPEC_W-2];

      unique case (op)
         OP_AND:  result = src_a & opnd_b;
         OP_OR:   result = src_a | opnd_b;
         OP_XOR:  result = src_a ^ opnd_b;
         OP_SPCL: begin
            if (is_shift)    result = sh_out;
            else if (is_sel) result = cond_true ? src_a : src_b;
            else             result = '0;
         end
         default: result = sum;
      endcase

      nxt.z = (result == '0);
      nxt.n = result[W-1];
      nxt.v = is_arith & add_v;
      nxt.c = is_arith ? add_c : (is_shift & sh_c);
      flags_out = (flag_en && !illegal) ? nxt : cur;
   end

   always_comb begin
      if (!flag_en)
         assert_flags_hold_R8: assert (flags_out == flags_in);
      if (illegal)
         assert_illegal_quiet_R12: assert (result == '0 && flags_out == flags_in);
      if (flag_en && !illegal) begin
         assert_zero_flag_R9: assert (flags_out[3] == (result == '0));
         if (!is_arith)
            assert_v_clear_R10: assert (!flags_out[1]);
      end
   end
endmodule

// File: tb/alu_exec_tb.sv
`timescale 1ns/1ps
module alu_exec_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] imm = '0;
   logic        use_imm = 1'b0, imm_high = 1'b0, flag_en = 1'b0, cond_true = 1'b0;
   logic [2:0]  op_code = '0;
   logic [4:0]  spec_fn = '0;
   logic [3:0]  flags_in = '0;
   logic [31:0] result;
   logic [3:0]  flags_out;
   logic        illegal;

   alu_exec u_dut (
      .src_a(src_a), .src_b(src_b), .imm(imm), .use_imm(use_imm),
      .imm_high(imm_high), .op_code(op_code), .spec_fn(spec_fn),
      .flag_en(flag_en), .flags_in(flags_in), .cond_true(cond_true),
      .result(result), .flags_out(flags_out), .illegal(illegal)
   );

   typedef struct {
      logic [31:0] res;
      logic [3:0]  flg;
      logic        ill;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] k, input logic ui, input logic h, input logic [2:0] op,
      input logic [4:0] sp, input logic fe, input logic [3:0] fi, input logic ct);
      exp_t e;
      logic [31:0] bb, r;
      logic [32:0] w;
      logic v, c, bad, shift, ar;
      longint amt;
      v = 0; c = 0; bad = 0; r = '0;
      if (!ui) bb = b;
      else if (op == 3'b111) bb = {{16{k[15]}}, k};
      else if (h) bb = {k, (op == 3'b100) ? 16'hFFFF : 16'h0000};
      else bb = {(op == 3'b100) ? 16'hFFFF : 16'h0000, k};
      case (op)
         3'b000, 3'b001, 3'b010, 3'b011: begin
            logic [31:0] ad;
            logic ci;
            ad = op[1] ? ~bb : bb;
            ci = (op == 3'b000) ? 1'b0 : (op == 3'b010) ? 1'b1 : fi[0];
            w = {1'b0, a} + {1'b0, ad} + {32'd0, ci};
            r = w[31:0];
            c = w[32];
            v = (a[31] == ad[31]) && (r[31] != a[31]);
         end
         3'b100: r = a & bb;
         3'b101: r = a | bb;
         3'b110: r = a ^ bb;
         default: begin
            shift = ui || sp[4];
            ar    = ui ? h : sp[3];
            if (shift) begin
               amt = longint'($signed(bb));
               if (amt == 0) r = a;
               else if (amt > 0 && amt < 32) begin
                  r = a << amt;
                  c = a[32 - amt];
               end else if (amt >= 32) r = '0;
               else if (amt > -32) r = ar ? 32'($signed(a) >>> (-amt)) : (a >> (-amt));
               else r = (ar && a[31]) ? '1 : '0;
            end else if (!ui && sp == 5'd0) r = ct ? a : b;
            else bad = 1;
         end
      endcase
      e.res = r;
      e.ill = bad;
      e.flg = (fe && !bad) ? {r == 0, r[31], v, c} : fi;
      return e;
   endfunction

   task automatic drive(input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] k, input logic ui, input logic h, input logic [2:0] op,
      input logic [4:0] sp, input logic fe, input logic [3:0] fi, input logic ct,
      input string tag);
      exp_t e;
      @(negedge clk);
      src_a = a; src_b = b; imm = k; use_imm = ui; imm_high = h; op_code = op;
      spec_fn = sp; flag_en = fe; flags_in = fi; cond_true = ct;
      e = model(a, b, k, ui, h, op, sp, fe, fi, ct);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares outputs at the edge after each drive
   always @(posedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (result !== e.res || flags_out !== e.flg || illegal !== e.ill) begin
            fails++;
            $display("FAIL %s: got res=%h flg=%b ill=%b, exp res=%h flg=%b ill=%b",
                     e.tag, result, flags_out, illegal, e.res, e.flg, e.ill);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // all-zero word behaves as a no-op add: Z set
      drive(0, 0, 16'h0, 1, 0, 3'b000, 0, 1, 4'b0000, 0, "R9 zero add");
      drive(32'h10, 0, 16'h1234, 1, 0, 3'b000, 0, 1, 4'b0000, 0, "R1 low half");
      drive(32'h1, 0, 16'h8000, 1, 1, 3'b000, 0, 1, 4'b0000, 0, "R1 high half, R9 N");
      drive(32'hDEADBEEF, 0, 16'h00FF, 1, 0, 3'b100, 0, 1, 4'b0000, 0, "R2 and low");
      drive(32'hDEADBEEF, 0, 16'hFF00, 1, 1, 3'b100, 0, 1, 4'b0000, 0, "R2 and high");
      drive(32'h7FFFFFFF, 1, 0, 0, 0, 3'b000, 0, 1, 4'b0000, 0, "R10 add overflow");
      drive(32'hFFFFFFFF, 1, 0, 0, 0, 3'b000, 0, 1, 4'b0000, 0, "R11 add carry");
      drive(5, 6, 0, 0, 0, 3'b001, 0, 1, 4'b0001, 0, "R3 addc C=1");
      drive(5, 7, 0, 0, 0, 3'b010, 0, 1, 4'b0001, 0, "R3 sub negative");
      drive(7, 5, 0, 0, 0, 3'b010, 0, 1, 4'b0000, 0, "R11 sub carry");
      drive(7, 5, 0, 0, 0, 3'b011, 0, 1, 4'b0000, 0, "R3 subb C=0");
      drive(32'h80000000, 1, 0, 0, 0, 3'b010, 0, 1, 4'b0000, 0, "R10 sub overflow");
      drive(32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 0, 3'b101, 0, 1, 4'b1111, 0, "R4 or, R11 C clear");
      drive(32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 0, 3'b110, 0, 1, 4'b1111, 0, "R4 xor, R10 V clear");
      drive(32'hF000000F, 4, 0, 0, 0, 3'b111, 5'b10000, 1, 4'b0000, 0, "R5 left 4, R11 C out");
      drive(32'h80000000, 32'hFFFFFFFC, 0, 0, 0, 3'b111, 5'b10101, 1, 4'b0001, 0, "R5 logical right");
      drive(32'h80000000, 32'hFFFFFFFC, 0, 0, 0, 3'b111, 5'b11010, 1, 4'b0001, 0, "R6 arith right");
      drive(32'h12345678, 0, 0, 0, 0, 3'b111, 5'b10000, 1, 4'b0000, 0, "R5 zero amount");
      drive(32'h80000000, 0, 16'hFFF8, 1, 1, 3'b111, 0, 1, 4'b0000, 0, "R5 const arith right");
      drive(32'h80000001, 0, 16'h001F, 1, 0, 3'b111, 0, 1, 4'b0000, 0, "R5 const left 31");
      drive(32'h80000000, 0, 16'hFFE1, 1, 0, 3'b111, 0, 1, 4'b0000, 0, "R5 const logical -31");
      drive(32'hFFFFFFFF, 0, 16'd40, 1, 0, 3'b111, 0, 1, 4'b0001, 0, "R7 left 40");
      drive(32'h80000000, 0, 16'hFFD8, 1, 1, 3'b111, 0, 1, 4'b0000, 0, "R7 arith -40");
      drive(32'h80000000, 32'h80000000, 0, 0, 0, 3'b111, 5'b10000, 1, 4'b0000, 0, "R7 logical most negative");
      drive(32'hAAAA5555, 32'h5555AAAA, 0, 0, 0, 3'b111, 5'b00000, 1, 4'b0000, 1, "R6 select true");
      drive(32'hAAAA5555, 32'h5555AAAA, 0, 0, 0, 3'b111, 5'b00000, 1, 4'b0000, 0, "R6 select false");
      drive(32'h1234, 32'h5, 0, 0, 0, 3'b111, 5'b00001, 1, 4'b1010, 0, "R12 reserved 00001");
      drive(32'h1234, 32'h5, 0, 0, 0, 3'b111, 5'b01100, 1, 4'b0101, 1, "R12 reserved 01100");
      drive(32'h7, 0, 16'h0003, 1, 0, 3'b111, 5'b00001, 1, 4'b0000, 0, "R12 const ignores field");
      drive(32'h7FFFFFFF, 1, 0, 0, 0, 3'b000, 0, 0, 4'b0110, 0, "R8 flags held");
      drive(32'hFFFFFFFF, 0, 16'hFFFF, 1, 0, 3'b001, 0, 0, 4'b1001, 0, "R8 flags held addc");
      // pseudo-random sweep across all forms
      begin
         logic [31:0] lf;
         lf = 32'hACE1_1234;
         for (int i = 0; i < 300; i++) begin
            logic [31:0] x, y;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            x = lf * 32'h9E3779B1;
            y = (i % 3 == 0) ? {{27{lf[7]}}, lf[4:0]} : lf ^ 32'h5A5A0F0F;
            drive(x, y, lf[15:0], lf[16], lf[17], lf[20:18], lf[25:21], lf[26],
                  lf[30:27], lf[31], "R3 R4 R5 R9 R11 sweep");
         end
      end
      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule